// File: doc/BRIEF.md
# Chained Vector Multiply-Add Unit

This block is a small vector execution unit. It holds a file of vector registers, a pipelined integer multiplier and a pipelined integer adder. Each unit takes an instruction with a destination, two source registers and an element count. The multiplier computes `Vd = Va * Vb` and the adder computes `Ve = Vx + Vy`. Both work one element per cycle in increasing index order. Integer arithmetic truncated to the element width stands in for floating point.

An add may name as a source the destination of a multiply that is still streaming. In that case each product is written back as it leaves the last multiplier stage. On the same cycle the product is also forwarded into the adder input, where it meets the other operand element with the same index. While the two instructions overlap, the unit writes a product and a sum in the same cycle. If the multiply has already finished, or the add reads registers the multiply does not write, the add reads its operands from the register file.

A host port writes vector elements and reads them back with one cycle of latency. The issue port has a single valid line and reports whether the unit selected by the opcode can take the instruction. Each unit has its own sequencer with four named states: `SQ_IDLE`, `SQ_STREAM`, `SQ_DRAIN` and `SQ_FINISH`. The transitions are:
- `SQ_IDLE` to `SQ_STREAM` on an accepted instruction.
- `SQ_STREAM` to `SQ_DRAIN` once the element with index length minus one has entered the pipeline.
- `SQ_DRAIN` to `SQ_FINISH` when the pipeline holds no element.
- `SQ_FINISH` to `SQ_STREAM` on an instruction accepted that cycle, otherwise to `SQ_IDLE`.

Top module: `vcm_chain_unit`

## Requirements
- R1: After reset, every element of every vector register reads as 0, both busy flags and both done flags are low, and `iss_ready` is high for either opcode.
- R2: A host write stores `host_wdata` into element `host_idx` of register `host_reg` at the clock edge. The element addressed by `host_reg`/`host_idx` appears on `host_rdata` one clock edge after the address is presented.
- R3: A multiply (`iss_op` = 0) with length L sets `Vd[k]` to the low DW bits of `Va[k] * Vb[k]` for every k below L. Products are written in increasing index order.
- R4: An add (`iss_op` = 1) with length L sets `Ve[k]` to the low DW bits of `Vx[k] + Vy[k]` for every k below L. Sums are written in increasing index order.
- R5: Elements at index L or above in the destination register keep their previous contents. This includes the boundary lengths 1 and MAXLEN. The issue length must lie in 1 to MAXLEN.
- R6: An add whose source is the destination of a multiply still in progress is accepted while the multiply is busy and yields the element-wise result of R4 on the final products. When it is accepted on the edge right after the multiply, with equal lengths, its done pulse comes exactly ADD_LAT cycles after the multiply's done pulse.
- R7: An add issued after the multiply that produces its source has completed gives the same values as a chained add.
- R8: While a unit is busy, `iss_ready` is low for that unit's opcode. An instruction offered then is not taken and leaves its destination register unchanged.
- R9: A unit's busy flag is high from the cycle after acceptance until its pipeline has drained. Its done flag is then high for exactly one cycle, with busy low. Results are written only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered this cycle |
| iss_op | input | 1 | 0 = multiply, 1 = add |
| iss_vd | input | RW | Destination register |
| iss_va | input | RW | First source register |
| iss_vb | input | RW | Second source register |
| iss_len | input | LW | Element count, 1 to MAXLEN |
| iss_ready | output | 1 | The unit chosen by `iss_op` can accept |
| host_we | input | 1 | Host element write enable |
| host_reg | input | RW | Host register select |
| host_idx | input | IW | Host element select |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Registered host read data |
| mul_busy | output | 1 | Multiplier streaming or draining |
| mul_done | output | 1 | One-cycle multiply completion pulse |
| add_busy | output | 1 | Adder streaming or draining |
| add_done | output | 1 | One-cycle add completion pulse |

## Verification
The properties rely on three conditions at the inputs. Every offered length is between 1 and MAXLEN. The host port is used only while both units are idle. No instruction writes a register that a still-running instruction reads, apart from the forwarded multiply destination. The bench loads and checks registers only after both busy flags have fallen, and it chooses register sets so that every concurrent pair either chains legally or shares no destination with the other's sources. Under these conditions, the write order and the done timing checked by the properties follow from the sequencers alone.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STREAM,
        SQ_DRAIN,
        SQ_FINISH
    } seq_state_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_ADD = 1'b1
    } vop_e;

endpackage

// File: rtl/vcm_regfile.sv
module vcm_regfile #(
    parameter int NREG   = 8,
    parameter int MAXLEN = 64,
    parameter int DW     = 16,
    parameter int NWR    = 3,
    parameter int NRD    = 5,
    localparam int RW    = $clog2(NREG),
    localparam int IW    = $clog2(MAXLEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWR-1:0]           wr_en,
    input  logic [NWR-1:0][RW-1:0]   wr_reg,
    input  logic [NWR-1:0][IW-1:0]   wr_idx,
    input  logic [NWR-1:0][DW-1:0]   wr_data,
    input  logic [NRD-1:0][RW-1:0]   rd_reg,
    input  logic [NRD-1:0][IW-1:0]   rd_idx,
    output logic [NRD-1:0][DW-1:0]   rd_data
);

    logic [DW-1:0] mem [NREG][MAXLEN];

    // later write ports win on a collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                for (int e = 0; e < MAXLEN; e++) begin
                    mem[r][e] <= '0;
                end
            end
        end else begin
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p]) begin
                    mem[wr_reg[p]][wr_idx[p]] <= wr_data[p];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rd_data[g] = mem[rd_reg[g]][rd_idx[g]];
        end
    endgenerate

endmodule

// File: rtl/vcm_pipe.sv
module vcm_pipe
    import vcm_pkg::*;
#(
    parameter int   STAGES = 4,
    parameter int   DW     = 16,
    parameter int   IW     = 6,
    parameter int   RW     = 3,
    parameter vop_e OP     = OP_MUL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [IW-1:0] in_idx,
    input  logic [RW-1:0] in_dst,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [IW-1:0] out_idx,
    output logic [RW-1:0] out_dst,
    output logic          empty
);

    logic [DW-1:0] res;

    generate
        if (OP == OP_MUL) begin : g_mul
            logic [2*DW-1:0] full;
            assign full = (2*DW)'(in_a) * (2*DW)'(in_b);
            assign res  = full[DW-1:0];
        end else begin : g_add
            assign res = in_a + in_b;
        end
    endgenerate

    logic [STAGES-1:0] vld;
    logic [DW-1:0]     dat [STAGES];
    logic [IW-1:0]     idx [STAGES];
    logic [RW-1:0]     dst [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld[0] <= in_valid;
            for (int s = 1; s < STAGES; s++) begin
                vld[s] <= vld[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        dat[0] <= res;
        idx[0] <= in_idx;
        dst[0] <= in_dst;
        for (int s = 1; s < STAGES; s++) begin
            dat[s] <= dat[s-1];
            idx[s] <= idx[s-1];
            dst[s] <= dst[s-1];
        end
    end

    assign out_valid = vld[STAGES-1];
    assign out_data  = dat[STAGES-1];
    assign out_idx   = idx[STAGES-1];
    assign out_dst   = dst[STAGES-1];
    assign empty     = ~|vld;

endmodule

// File: rtl/vcm_seq.sv
module vcm_seq
    import vcm_pkg::*;
#(
    parameter int MAXLEN = 64,
    parameter int RW     = 3,
    localparam int IW    = $clog2(MAXLEN),
    localparam int LW    = $clog2(MAXLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] start_dst,
    input  logic [RW-1:0] start_sa,
    input  logic [RW-1:0] start_sb,
    input  logic [LW-1:0] start_len,
    input  logic          go,
    input  logic          pipe_empty,
    output logic          busy,
    output logic          done,
    output logic          ready,
    output logic          issue,
    output logic [IW-1:0] ptr,
    output logic [RW-1:0] dst,
    output logic [RW-1:0] sa,
    output logic [RW-1:0] sb,
    output logic [LW-1:0] len
);

    seq_state_e st, nxt;
    logic       last;

    assign last = (LW'(ptr) == len - LW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            SQ_IDLE:   if (start)            nxt = SQ_STREAM;
            SQ_STREAM: if (go && last)       nxt = SQ_DRAIN;
            SQ_DRAIN:  if (pipe_empty)       nxt = SQ_FINISH;
            SQ_FINISH: nxt = start ? SQ_STREAM : SQ_IDLE;
            default:   nxt = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (st == SQ_STREAM) || (st == SQ_DRAIN);
        done  = (st == SQ_FINISH);
        ready = !busy;
        issue = (st == SQ_STREAM) && go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            dst <= '0;
            sa  <= '0;
            sb  <= '0;
            len <= LW'(1);
        end else if (start && ready) begin
            ptr <= '0;
            dst <= start_dst;
            sa  <= start_sa;
            sb  <= start_sb;
            len <= start_len;
        end else if (issue && !last) begin
            ptr <= ptr + IW'(1);
        end
    end

endmodule

// File: rtl/vcm_chain_unit.sv
module vcm_chain_unit
    import vcm_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int MAXLEN  = 64,
    parameter int DW      = 16,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 3,
    localparam int RW     = $clog2(NREG),
    localparam int IW     = $clog2(MAXLEN),
    localparam int LW     = $clog2(MAXLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic          iss_op,
    input  logic [RW-1:0] iss_vd,
    input  logic [RW-1:0] iss_va,
    input  logic [RW-1:0] iss_vb,
    input  logic [LW-1:0] iss_len,
    output logic          iss_ready,
    input  logic          host_we,
    input  logic [RW-1:0] host_reg,
    input  logic [IW-1:0] host_idx,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          mul_busy,
    output logic          mul_done,
    output logic          add_busy,
    output logic          add_done
);

    localparam int NRD = 5;
    localparam int NWR = 3;

    logic mul_ready, add_ready, start_mul, start_add;
    logic mul_issue, add_issue, add_go;
    logic mul_empty, add_empty;
    logic [IW-1:0] mul_ptr, add_ptr;
    logic [RW-1:0] mul_dst, mul_sa, mul_sb, add_dst, add_sa, add_sb;
    logic [LW-1:0] mul_len, add_len;

    logic          mul_out_valid, add_out_valid;
    logic [DW-1:0] mul_out_data, add_out_data;
    logic [IW-1:0] mul_out_idx, add_out_idx;
    logic [RW-1:0] mul_out_dst, add_out_dst;

    logic [NRD-1:0][RW-1:0] rd_reg;
    logic [NRD-1:0][IW-1:0] rd_idx;
    logic [NRD-1:0][DW-1:0] rd_data;
    logic [LW-1:0]          mul_wcnt;
    logic [DW-1:0]          add_opa, add_opb;

    assign iss_ready = (iss_op == OP_ADD) ? add_ready : mul_ready;
    assign start_mul = iss_valid && (iss_op == OP_MUL) && mul_ready;
    assign start_add = iss_valid && (iss_op == OP_ADD) && add_ready;

    vcm_seq #(.MAXLEN(MAXLEN), .RW(RW)) i_mul_seq (
        .clk(clk), .rst_n(rst_n), .start(start_mul),
        .start_dst(iss_vd), .start_sa(iss_va), .start_sb(iss_vb), .start_len(iss_len),
        .go(1'b1), .pipe_empty(mul_empty),
        .busy(mul_busy), .done(mul_done), .ready(mul_ready), .issue(mul_issue),
        .ptr(mul_ptr), .dst(mul_dst), .sa(mul_sa), .sb(mul_sb), .len(mul_len)
    );

    vcm_seq #(.MAXLEN(MAXLEN), .RW(RW)) i_add_seq (
        .clk(clk), .rst_n(rst_n), .start(start_add),
        .start_dst(iss_vd), .start_sa(iss_va), .start_sb(iss_vb), .start_len(iss_len),
        .go(add_go), .pipe_empty(add_empty),
        .busy(add_busy), .done(add_done), .ready(add_ready), .issue(add_issue),
        .ptr(add_ptr), .dst(add_dst), .sa(add_sa), .sb(add_sb), .len(add_len)
    );

    // products of the running multiply already written back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             mul_wcnt <= '0;
        else if (start_mul)     mul_wcnt <= '0;
        else if (mul_out_valid) mul_wcnt <= mul_wcnt + LW'(1);
    end

    // chaining: an add operand that the running multiply still owes
    // is taken from the multiplier output on the cycle it appears
    logic mul_cov, hit_a, hit_b, at_out, written, ok_a, ok_b;
    always_comb begin
        mul_cov = mul_busy && (LW'(add_ptr) < mul_len);
        hit_a   = mul_cov && (add_sa == mul_dst);
        hit_b   = mul_cov && (add_sb == mul_dst);
        at_out  = mul_out_valid && (mul_out_idx == add_ptr);
        written = LW'(add_ptr) < mul_wcnt;
        ok_a    = !hit_a || written || at_out;
        ok_b    = !hit_b || written || at_out;
        add_go  = ok_a && ok_b;
        add_opa = (hit_a && at_out) ? mul_out_data : rd_data[2];
        add_opb = (hit_b && at_out) ? mul_out_data : rd_data[3];
    end

    assign rd_reg = {host_reg, add_sb, add_sa, mul_sb, mul_sa};
    assign rd_idx = {host_idx, add_ptr, add_ptr, mul_ptr, mul_ptr};

    vcm_regfile #(.NREG(NREG), .MAXLEN(MAXLEN), .DW(DW), .NWR(NWR), .NRD(NRD)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en({add_out_valid, mul_out_valid, host_we}),
        .wr_reg({add_out_dst, mul_out_dst, host_reg}),
        .wr_idx({add_out_idx, mul_out_idx, host_idx}),
        .wr_data({add_out_data, mul_out_data, host_wdata}),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    vcm_pipe #(.STAGES(MUL_LAT), .DW(DW), .IW(IW), .RW(RW), .OP(OP_MUL)) i_mul_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(mul_issue),
        .in_a(rd_data[0]), .in_b(rd_data[1]), .in_idx(mul_ptr), .in_dst(mul_dst),
        .out_valid(mul_out_valid), .out_data(mul_out_data),
        .out_idx(mul_out_idx), .out_dst(mul_out_dst), .empty(mul_empty)
    );

    vcm_pipe #(.STAGES(ADD_LAT), .DW(DW), .IW(IW), .RW(RW), .OP(OP_ADD)) i_add_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(add_issue),
        .in_a(add_opa), .in_b(add_opb), .in_idx(add_ptr), .in_dst(add_dst),
        .out_valid(add_out_valid), .out_data(add_out_data),
        .out_idx(add_out_idx), .out_dst(add_out_dst), .empty(add_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= rd_data[4];
    end

endmodule

// File: rtl/vcm_chain_checker.sv
module vcm_chain_checker #(
    parameter int MAXLEN = 64,
    localparam int IW    = $clog2(MAXLEN),
    localparam int LW    = $clog2(MAXLEN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic [LW-1:0] iss_len,
    input logic          mul_start,
    input logic          add_start,
    input logic          mul_wr,
    input logic [IW-1:0] mul_wr_idx,
    input logic          add_wr,
    input logic [IW-1:0] add_wr_idx,
    input logic [LW-1:0] mul_len,
    input logic [LW-1:0] add_len,
    input logic          mul_busy,
    input logic          add_busy,
    input logic          mul_done,
    input logic          add_done
);

    logic [IW-1:0] mul_exp, add_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_exp <= '0;
            add_exp <= '0;
        end else begin
            if (mul_start)   mul_exp <= '0;
            else if (mul_wr) mul_exp <= mul_exp + IW'(1);
            if (add_start)   add_exp <= '0;
            else if (add_wr) add_exp <= add_exp + IW'(1);
        end
    end

    a_r3_mul_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        mul_wr |-> (mul_wr_idx == mul_exp));
    a_r4_add_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        add_wr |-> (add_wr_idx == add_exp));
    a_r5_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_len >= LW'(1) && iss_len <= LW'(MAXLEN)));
    a_r5_mul_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        mul_wr |-> (LW'(mul_wr_idx) < mul_len));
    a_r5_add_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        add_wr |-> (LW'(add_wr_idx) < add_len));
    a_r8_mul_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        mul_busy |-> !mul_start);
    a_r8_add_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        add_busy |-> !add_start);
    a_r9_mul_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |=> mul_busy);
    a_r9_add_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        add_start |=> add_busy);
    a_r9_mul_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mul_wr |-> mul_busy);
    a_r9_add_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
        add_wr |-> add_busy);
    a_r9_mul_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |=> !mul_done);
    a_r9_add_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        add_done |=> !add_done);
    a_r9_mul_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> !mul_busy);

endmodule

bind vcm_chain_unit vcm_chain_checker #(.MAXLEN(MAXLEN)) i_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_len(iss_len),
    .mul_start(start_mul), .add_start(start_add),
    .mul_wr(mul_out_valid), .mul_wr_idx(mul_out_idx),
    .add_wr(add_out_valid), .add_wr_idx(add_out_idx),
    .mul_len(mul_len), .add_len(add_len),
    .mul_busy(mul_busy), .add_busy(add_busy),
    .mul_done(mul_done), .add_done(add_done)
);

// File: tb/test_vcm_chain_unit.sv
`timescale 1ns/1ps
module test_vcm_chain_unit;

    localparam int NREG = 8, MAXLEN = 64, DW = 16, ML = 4, AL = 3;
    localparam int RW = $clog2(NREG), IW = $clog2(MAXLEN), LW = $clog2(MAXLEN + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0, iss_op = 1'b0;
    logic [RW-1:0] iss_vd = '0, iss_va = '0, iss_vb = '0;
    logic [LW-1:0] iss_len = LW'(1);
    logic          iss_ready;
    logic          host_we = 1'b0;
    logic [RW-1:0] host_reg = '0;
    logic [IW-1:0] host_idx = '0;
    logic [DW-1:0] host_wdata = '0, host_rdata;
    logic          mul_busy, mul_done, add_busy, add_done;

    vcm_chain_unit #(.NREG(NREG), .MAXLEN(MAXLEN), .DW(DW), .MUL_LAT(ML), .ADD_LAT(AL)) i_vcm_chain_unit (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vd(iss_vd), .iss_va(iss_va), .iss_vb(iss_vb), .iss_len(iss_len),
        .iss_ready(iss_ready), .host_we(host_we), .host_reg(host_reg),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mul_busy(mul_busy), .mul_done(mul_done), .add_busy(add_busy), .add_done(add_done)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_errors = 0, cyc = 0;
    logic [DW-1:0] model [NREG][MAXLEN];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int r, input int i, input logic [DW-1:0] d);
        host_we = 1'b1; host_reg = RW'(r); host_idx = IW'(i); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        model[r][i] = d;
    endtask

    task automatic host_read(input int r, input int i, output logic [DW-1:0] d);
        host_reg = RW'(r); host_idx = IW'(i);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic load_reg(input int r, input int seed);
        for (int i = 0; i < MAXLEN; i++)
            host_write(r, i, DW'(seed * 37 + i * i * 13 + i * 4099));
    endtask

    task automatic check_reg(input int r, input string tag);
        logic [DW-1:0] d;
        int bad = -1;
        logic [DW-1:0] got = '0;
        for (int i = 0; i < MAXLEN; i++) begin
            host_read(r, i, d);
            if (d !== model[r][i] && bad < 0) begin bad = i; got = d; end
        end
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, $sformatf("%s V%0d[%0d]", tag, r, bad), got, model[r][bad]);
    endtask

    task automatic issue(input bit op, input int vd, input int va, input int vb, input int len,
                         output bit acc);
        iss_valid = 1'b1; iss_op = op; iss_vd = RW'(vd); iss_va = RW'(va);
        iss_vb = RW'(vb); iss_len = LW'(len);
        #1 acc = iss_ready;
        @(negedge clk);
        iss_valid = 1'b0;
        if (acc) begin
            for (int k = 0; k < len; k++)
                model[vd][k] = op ? DW'(model[va][k] + model[vb][k])
                                  : DW'(model[va][k] * model[vb][k]);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 400 && (mul_busy || add_busy); n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        check(!mul_busy && !add_busy && !mul_done && !add_done, "R1 flags", mul_busy, 0);
        iss_op = 1'b0; #1 check(iss_ready, "R1 ready mul", iss_ready, 1);
        iss_op = 1'b1; #1 check(iss_ready, "R1 ready add", iss_ready, 1);
        host_read(0, 0, d);  check(d == 0, "R1 V0[0]", d, 0);
        host_read(7, 63, d); check(d == 0, "R1 V7[63]", d, 0);
    endtask

    task automatic t_host();
        logic [DW-1:0] d;
        host_write(5, 17, 16'hBEEF);
        host_read(5, 17, d);
        check(d == 16'hBEEF, "R2 host readback", d, 16'hBEEF);
    endtask

    task automatic t_chained();
        bit a1, a2;
        int tm = -1, ta = -1, mdh = 0;
        issue(1'b0, 2, 0, 1, 64, a1);
        check(a1, "R3 mul accepted", a1, 1);
        check(mul_busy, "R9 busy after accept", mul_busy, 1);
        issue(1'b1, 4, 2, 3, 64, a2);
        check(a2, "R6 chained add accepted while mul busy", a2, 1);
        for (int n = 0; n < 400 && ta < 0; n++) begin
            if (mul_done) begin
                mdh++;
                tm = cyc;
                check(!mul_busy, "R9 busy low at done", mul_busy, 0);
            end
            if (add_done) ta = cyc;
            @(negedge clk);
        end
        check(mdh == 1, "R9 done one cycle", mdh, 1);
        check(ta - tm == AL, "R6 chained add done offset", ta - tm, AL);
        wait_idle();
        check_reg(2, "R3 chained products");
        check_reg(4, "R6 chained sums");
    endtask

    task automatic t_after();
        bit a;
        issue(1'b0, 5, 1, 3, 64, a); wait_idle();
        issue(1'b1, 6, 5, 0, 64, a); wait_idle();
        check(a, "R7 add accepted", a, 1);
        check_reg(6, "R7 unchained sums");
        check_reg(5, "R3 products");
    endtask

    task automatic t_short();
        bit a;
        load_reg(7, 91);
        issue(1'b0, 7, 0, 1, 5, a); wait_idle();
        check_reg(7, "R5 length 5 multiply");
        issue(1'b1, 7, 3, 0, 1, a); wait_idle();
        check_reg(7, "R5 length 1 add");
        issue(1'b1, 1, 1, 0, 64, a); wait_idle();
        check_reg(1, "R4 full length add in place");
    endtask

    task automatic t_reject();
        bit a1, a2;
        issue(1'b0, 4, 0, 3, 64, a1);
        issue(1'b0, 5, 1, 1, 4, a2);
        check(!a2, "R8 mul refused while busy", a2, 0);
        wait_idle();
        check_reg(5, "R8 refused destination unchanged");
        check_reg(4, "R3 first multiply intact");
    endtask

    task automatic t_late();
        bit a1, a2;
        issue(1'b0, 6, 0, 3, 64, a1);
        repeat (6) @(negedge clk);
        issue(1'b1, 7, 6, 1, 64, a2);
        check(a2 && mul_busy, "R6 late add taken while mul busy", {a2, mul_busy}, 3);
        wait_idle();
        check_reg(7, "R6 late chained sums");
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++)
            for (int i = 0; i < MAXLEN; i++) model[r][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host();
        load_reg(0, 3);
        for (int i = 0; i < MAXLEN; i++) host_write(1, i, DW'(16'hFFFF - i * 3));
        load_reg(3, 11);
        t_chained();
        t_after();
        t_short();
        t_reject();
        t_late();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule